// File: doc/BRIEF.md
# Serial EEPROM Station Address Loader

This block drives a three-wire serial EEPROM with 6-bit word addressing and acts as its read master. After reset, and again on every `start` pulse, it reads words 0 to 15 in a single pass and keeps them as a 32-byte image. Each 16-bit word is stored little-endian, so its low byte sits at the even byte address. From bytes 20 to 25 of that image it builds the 48-bit station address. When the last word has been captured, it raises `done` and `mac_valid` together.

Each word is read with its own EEPROM transaction. Select is first held low for one half-period and then raised while the shift clock is low. The block then shifts out a 9-bit read command and clocks in 16 data bits. Select drops once the word is complete. A divider stretches every shift-clock level to at least `HALF_CYC` system cycles, so the serial clock stays inside the EEPROM's rated speed.

The address output has a valid qualifier but no back-pressure. `mac_addr` holds steady for as long as `mac_valid` is high, and a consumer may sample it on any cycle in that window. The raw image can be read at any time through the `rd_addr`/`rd_data` port, which is combinational and has no handshake.

Top module: `eeprom_mac_loader`

## Requirements
- R1: Each word access starts with select low for at least `HALF_CYC` cycles. Select then rises while the shift clock is low, before any command bit.
- R2: The command is the 9-bit pattern `1,1,0` followed by the 6-bit word address, most significant bit first. The data-out line is set while the clock is low and does not change during a clock-high level; each bit is latched by the rising clock edge.
- R3: After the command, 16 data bits are taken most significant bit first. Each bit is sampled at the end of a clock-high level, and the clock then returns low.
- R4: Select drops after the sixteenth data bit of each word, ending the access.
- R5: One pass reads word addresses 0 to 15 in ascending order, one access per word.
- R6: `rd_data` returns the stored word at `rd_addr`: bits 7:0 are byte 2·`rd_addr` and bits 15:8 are byte 2·`rd_addr`+1.
- R7: `mac_addr[47:40]` is image byte 20, `mac_addr[39:32]` is byte 21, and so on down to `mac_addr[7:0]`, which is byte 25. `mac_addr` is stable while `mac_valid` is high.
- R8: `done` and `mac_valid` are low from reset until all 16 words of a pass are captured. After that they are high together until the next `start`.
- R9: Every shift-clock high and low level lasts at least `HALF_CYC` system cycles, except a level cut short by `start`.
- R10: `start` clears `done`/`mac_valid` on the following cycle, abandons any access in progress and begins a new pass at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; a pass begins on its release |
| start | input | 1 | Pulse to restart the pass from word 0 |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| rd_addr | input | 4 | Word index for the image read port |
| rd_data | output | 16 | Stored word at `rd_addr` |
| mac_addr | output | 48 | Assembled station address |
| mac_valid | output | 1 | `mac_addr` is valid |
| done | output | 1 | Pass complete |

## Verification
Some rules are checked by assertions on every cycle:
- select rises and falls only while the clock is low;
- data-out is steady through every clock-high level;
- no clock level is shorter than the divider allows;
- the address is stable while valid;
- `done` rises only in the cycle after a word is captured;
- `start` clears completion.

Other behaviour can only be shown by the bench's scenarios, which use a bit-level EEPROM model. These cover the command pattern and address order, whether data bits are sampled correctly, the little-endian image layout, the byte window that forms the address, and a restart that abandons a pass part-way.

// File: rtl/eeml_pkg.sv
package eeml_pkg;
  localparam int WORD_W = 16;
  localparam logic [2:0] CMD_READ = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESEL,
    ST_SEL,
    ST_CMD,
    ST_DATA,
    ST_END
  } rd_state_e;
endpackage

// File: rtl/eeml_tick.sv
module eeml_tick #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (HALF_CYC <= 1) begin : g_pass
      assign tick = run;
    end else begin : g_div
      localparam int CW = $clog2(HALF_CYC);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || tick)   cnt <= '0;
        else                     cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == CW'(HALF_CYC - 1));
    end
  endgenerate
endmodule

// File: rtl/eeml_word_rd.sv
module eeml_word_rd
  import eeml_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              abort,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ser_in,
  output logic              run,
  output logic              idle,
  output logic              cs,
  output logic              sk,
  output logic              di,
  output logic              word_ok,
  output logic [WORD_W-1:0] word
);
  localparam int CMD_W = ADDR_W + 3;
  localparam int MAXB  = (CMD_W > WORD_W) ? CMD_W : WORD_W;
  localparam int CNT_W = $clog2(MAXB + 1);

  rd_state_e        st;
  logic             ph;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] cmd_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= 1'b0;
      cnt     <= '0;
      cmd_sh  <= '0;
      word    <= '0;
      word_ok <= 1'b0;
    end else begin
      word_ok <= 1'b0;
      if (abort) begin
        st <= ST_IDLE;
        ph <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: if (go) begin
            st     <= ST_DESEL;
            cmd_sh <= {CMD_READ, addr};
            ph     <= 1'b0;
            cnt    <= '0;
          end
          ST_DESEL: if (tick) st <= ST_SEL;
          ST_SEL:   if (tick) st <= ST_CMD;
          ST_CMD: if (tick) begin
            ph <= ~ph;
            if (ph) begin
              cmd_sh <= {cmd_sh[CMD_W-2:0], 1'b0};
              if (cnt == CNT_W'(CMD_W - 1)) begin
                cnt <= '0;
                st  <= ST_DATA;
              end else cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: if (tick) begin
            ph <= ~ph;
            if (ph) begin
              word <= {word[WORD_W-2:0], ser_in};
              if (cnt == CNT_W'(WORD_W - 1)) begin
                cnt <= '0;
                st  <= ST_END;
              end else cnt <= cnt + 1'b1;
            end
          end
          ST_END: if (tick) begin
            st      <= ST_IDLE;
            word_ok <= 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign run  = (st != ST_IDLE);
  assign idle = (st == ST_IDLE);
  assign cs   = (st == ST_SEL) || (st == ST_CMD) || (st == ST_DATA) || (st == ST_END);
  assign sk   = ((st == ST_CMD) || (st == ST_DATA)) && ph;
  assign di   = (st == ST_CMD) && cmd_sh[CMD_W-1];
endmodule

// File: rtl/eeml_image.sv
module eeml_image
  import eeml_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int MAC_BYTE0 = 20,
  parameter int MAC_BYTES = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [$clog2(NUM_WORDS)-1:0] waddr,
  input  logic [WORD_W-1:0]            wdata,
  input  logic [$clog2(NUM_WORDS)-1:0] raddr,
  output logic [WORD_W-1:0]            rdata,
  output logic [8*MAC_BYTES-1:0]       mac
);
  localparam int BPW = WORD_W / 8;

  logic [WORD_W-1:0] mem [NUM_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  generate
    for (genvar i = 0; i < MAC_BYTES; i++) begin : g_mac
      localparam int BYTE_IX = MAC_BYTE0 + i;
      localparam int WORD_IX = BYTE_IX / BPW;
      localparam int LANE    = BYTE_IX % BPW;
      assign mac[8*(MAC_BYTES-i)-1 -: 8] = mem[WORD_IX][8*LANE +: 8];
    end
  endgenerate
endmodule

// File: rtl/eeprom_mac_loader.sv
module eeprom_mac_loader
  import eeml_pkg::*;
#(
  parameter int HALF_CYC  = 4,
  parameter int ADDR_W    = 6,
  parameter int NUM_WORDS = 16,
  parameter int MAC_BYTE0 = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         ee_cs,
  output logic                         ee_sk,
  output logic                         ee_di,
  input  logic                         ee_do,
  input  logic [$clog2(NUM_WORDS)-1:0] rd_addr,
  output logic [WORD_W-1:0]            rd_data,
  output logic [47:0]                  mac_addr,
  output logic                         mac_valid,
  output logic                         done
);
  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam int HC_W  = $clog2(HALF_CYC + 2);

  logic             active, done_q;
  logic [IDX_W-1:0] widx;
  logic             rd_run, rd_idle, word_ok, tick, go, we;
  logic [WORD_W-1:0] word;

  assign go = active && rd_idle && !start && !word_ok;
  assign we = active && word_ok && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b1;
      widx   <= '0;
      done_q <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      widx   <= '0;
      done_q <= 1'b0;
    end else if (active && word_ok) begin
      if (widx == IDX_W'(NUM_WORDS - 1)) begin
        active <= 1'b0;
        done_q <= 1'b1;
      end else begin
        widx <= widx + 1'b1;
      end
    end
  end

  eeml_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(rd_run), .tick(tick)
  );

  eeml_word_rd #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(start), .tick(tick),
    .addr(ADDR_W'(widx)), .ser_in(ee_do), .run(rd_run), .idle(rd_idle),
    .cs(ee_cs), .sk(ee_sk), .di(ee_di), .word_ok(word_ok), .word(word)
  );

  eeml_image #(.NUM_WORDS(NUM_WORDS), .MAC_BYTE0(MAC_BYTE0), .MAC_BYTES(6)) u_img (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(widx), .wdata(word),
    .raddr(rd_addr), .rdata(rd_data), .mac(mac_addr)
  );

  assign done      = done_q;
  assign mac_valid = done_q;

  // checker state: length of the current shift-clock level
  logic            sk_prev;
  logic [HC_W-1:0] hold_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_prev  <= 1'b0;
      hold_cnt <= HC_W'(HALF_CYC);
    end else begin
      sk_prev <= ee_sk;
      if (ee_sk != sk_prev)                  hold_cnt <= HC_W'(1);
      else if (hold_cnt < HC_W'(HALF_CYC))   hold_cnt <= hold_cnt + 1'b1;
    end
  end

  p_sel_clk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> !ee_sk);
  p_di_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  p_drop_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ee_cs) && !$past(start)) |-> !ee_sk);
  p_mac_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_valid && $past(mac_valid)) |-> $stable(mac_addr));
  p_done_after_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(word_ok));
  p_half_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ee_sk != sk_prev) && !$past(start)) |-> (hold_cnt >= HC_W'(HALF_CYC)));
  p_restart_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
endmodule

// File: tb/eeprom_mac_loader_tb.sv
`timescale 1ns/1ps
module eeprom_mac_loader_tb;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [47:0] mac_addr;
  logic        mac_valid, done;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  eeprom_mac_loader #(.HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .mac_addr(mac_addr), .mac_valid(mac_valid), .done(done)
  );

  // ---------------- EEPROM model ----------------
  logic [15:0] key = 16'hA5C3;
  int          bcnt = 0;
  logic [8:0]  cmd;
  logic [15:0] sh;
  int          nreads = 0;
  int          bad_cmd = 0;
  int          full_cnt = 0;
  logic [5:0]  addr_log [64];

  function automatic logic [15:0] word_of(input logic [5:0] a, input logic [15:0] k);
    return (16'(a) * 16'h1357) ^ k;
  endfunction

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      if (bcnt == 25) full_cnt++;
      bcnt = 0;
      ee_do <= 1'b0;
    end else if (bcnt < 9) begin
      cmd = {cmd[7:0], ee_di};
      bcnt++;
      if (bcnt == 9) begin
        if (cmd[8:6] != 3'b110) bad_cmd++;
        if (nreads < 64) addr_log[nreads] = cmd[5:0];
        nreads++;
        sh = word_of(cmd[5:0], key);
      end
    end else if (bcnt < 25) begin
      ee_do <= sh[15];
      sh = {sh[14:0], 1'b0};
      bcnt++;
    end
  end

  // ---------------- pin monitors ----------------
  logic p_sk = 1'b0, p_cs = 1'b0, p_di = 1'b0, p_valid = 1'b0;
  logic [47:0] p_mac = '0;
  int sk_len = 0, cs_low_len = 0;
  int r1_viol = 0, r2_viol = 0, r7_viol = 0, r8_viol = 0, r9_viol = 0;
  bit mon_en = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_cs && !p_cs && (ee_sk || cs_low_len < HALF)) r1_viol++;
      if (ee_sk && p_sk && ee_di !== p_di) r2_viol++;
      if (ee_sk != p_sk) begin
        if (mon_en && sk_len < HALF) r9_viol++;
        sk_len = 1;
      end else sk_len++;
      if (mac_valid !== done) r8_viol++;
      if (mac_valid && p_valid && mac_addr !== p_mac) r7_viol++;
      cs_low_len = ee_cs ? 0 : cs_low_len + 1;
    end else begin
      sk_len = HALF;
      cs_low_len = HALF;
    end
    p_sk = ee_sk; p_cs = ee_cs; p_di = ee_di; p_valid = mac_valid; p_mac = mac_addr;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_mac(input logic [15:0] k);
    logic [15:0] w10, w11, w12;
    w10 = word_of(6'd10, k); w11 = word_of(6'd11, k); w12 = word_of(6'd12, k);
    return {w10[7:0], w10[15:8], w11[7:0], w11[15:8], w12[7:0], w12[15:8]};
  endfunction

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(req, {63'd0, done}, 64'd1);
  endtask

  task automatic pulse_start();
    mon_en = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic check_pass(input int base, input logic [15:0] k);
    for (int i = 0; i < 16; i++)
      chk("R5 address order", {58'd0, addr_log[base + i]}, 64'(i));
    for (int i = 0; i < 16; i++) begin
      rd_addr = 4'(i);
      #1;
      chk("R3/R6 stored word", {48'd0, rd_data}, {48'd0, word_of(6'(i), k)});
    end
    chk("R7 station address", {16'd0, mac_addr}, {16'd0, exp_mac(k)});
    chk("R8 valid with done", {63'd0, mac_valid}, 64'd1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 select low in reset", {63'd0, ee_cs}, 64'd0);
    chk("R9 clock low in reset", {63'd0, ee_sk}, 64'd0);
    chk("R8 done low in reset", {63'd0, done}, 64'd0);
    chk("R8 valid low in reset", {63'd0, mac_valid}, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_first_pass();
    wait_done("R8 first pass completes");
    chk("R5 one access per word", 64'(nreads), 64'd16);
    chk("R2 command pattern", 64'(bad_cmd), 64'd0);
    chk("R4 select drops after 16 bits", 64'(full_cnt), 64'd16);
    check_pass(0, 16'hA5C3);
  endtask

  task automatic t_restart_idle();
    int base;
    key = 16'h3C69;
    pulse_start();
    chk("R10 done cleared by start", {63'd0, done}, 64'd0);
    chk("R10 valid cleared by start", {63'd0, mac_valid}, 64'd0);
    base = nreads;
    mon_en = 1'b1;
    wait_done("R10 pass after start completes");
    chk("R5 reads in second pass", 64'(nreads - base), 64'd16);
    check_pass(base, 16'h3C69);
  endtask

  task automatic t_restart_mid();
    int base, fulls;
    key = 16'h0FF1;
    pulse_start();
    mon_en = 1'b1;
    base = nreads;
    while (nreads < base + 5) @(negedge clk);
    repeat (20) @(negedge clk);
    key = 16'h7E18;
    fulls = full_cnt;
    pulse_start();
    chk("R10 done low after mid-pass start", {63'd0, done}, 64'd0);
    base = nreads;
    mon_en = 1'b1;
    wait_done("R10 restarted pass completes");
    chk("R4 no extra full access on abort", 64'(full_cnt - fulls), 64'd16);
    check_pass(base, 16'h7E18);
  endtask

  task automatic t_pins();
    chk("R1 select rise rule", 64'(r1_viol), 64'd0);
    chk("R2 data steady while clock high", 64'(r2_viol), 64'd0);
    chk("R7 address stable while valid", 64'(r7_viol), 64'd0);
    chk("R8 valid tracks done", 64'(r8_viol), 64'd0);
    chk("R9 minimum half period", 64'(r9_viol), 64'd0);
  endtask

  initial begin
    t_reset();
    t_first_pass();
    t_restart_idle();
    t_restart_mid();
    t_pins();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule